// File: doc/BRIEF.md
# External Peripheral Bus Controller

This block sits between an internal single-request bus and slow external devices such as boot ROM, flash, static RAM and memory-mapped slave peripherals. Eight chip-select banks each decode their own address window and carry their own device data width and strobe-timing profile. A request that falls in a bank's window becomes one or more external device cycles. Each cycle shapes the chip select, output enable and write enable around a stable address. The block inserts wait states, can hold chip select across a burst, and can stretch a cycle until the device raises Ready. A timeout guards that wait.

The bank settings are written through a simple configuration port, two 32-bit words per bank. A request is accepted only while `req_ready` is high. The answer comes back as a one-cycle `resp_valid` pulse carrying read data and an error flag. Timing settings are copied when a request is accepted, so writing the configuration during an access does not change that access.

Top module: `ext_bus_ctrl`

## Requirements
- R1: A configuration write with `cfg_sel`=0 sets a bank's map word and one with `cfg_sel`=1 sets its timing word. Map word: bits 31:20 base, bits 19:8 mask, bit 7 valid, bits 1:0 width. A bank matches when valid and `(req_addr[31:20] ^ base) & mask` is zero. When several banks match, the lowest-numbered bank is used. After reset no bank is valid.
- R2: A request that matches no bank gets `resp_valid` with `resp_err`=1 in the cycle after it is accepted. No chip select asserts.
- R3: Timing word fields: 7:0 non-burst waits W, 12:8 first-burst waits F, 15:13 subsequent-burst waits S, 17:16 CS-on delay, 19:18 CS-off hold, 21:20 OE-on, 23:22 WE-on, 25:24 WE-off, 26 burst, 27 Ready mode, 28 timeout disable. A non-burst device cycle drives the address for CS-on cycles with CS high. CS is then low for W+1 cycles, and the address is held for CS-off cycles after CS rises.
- R4: During a read, OE goes low OE-on cycles after CS falls and stays low until CS rises. During a write, WE is low in active cycle c (counted from 0) when c ≥ WE-on and c + WE-off ≤ the beat's wait count. OE and WE are never low with all chip selects high.
- R5: Width encoding 0 = 8 bit, 1 = 16 bit, 2 or 3 = 32 bit. Device data uses the low lanes of `ext_dout`/`ext_din`. A request wider than the bank is split into device beats at byte addresses that rise by the device width. Beats are taken low part first, so read data is assembled little-endian and write data is sent little-endian.
- R6: With burst set, all beats of a request share one chip-select assertion. The first beat is active for F+1 cycles and each later beat for S+1 cycles. OE stays low across later read beats.
- R7: In Ready mode a beat ends on the first cycle at or after its wait count in which `ext_ready` is high. Read data is taken in that cycle. Outside Ready mode `ext_ready` has no effect.
- R8: In Ready mode with the timeout enabled, a beat still waiting after 2048 active cycles is ended. The request then completes with `resp_err`=1 and read data 0. With the timeout disabled the beat waits for Ready indefinitely.
- R9: At most one chip select is low at a time, and OE and WE are never low together.
- R10: `req_size` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Read data above the requested size reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 3 | Bank index for the configuration write |
| cfg_sel | input | 1 | 0 = map word, 1 = timing word |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Request size code |
| req_addr | input | 32 | Byte address, aligned to the size |
| req_wdata | input | 32 | Write data, little-endian |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | No bank matched or Ready timed out |
| resp_rdata | output | 32 | Assembled read data |
| ext_addr | output | 32 | External byte address |
| ext_cs_n | output | 8 | Chip selects, active low |
| ext_oe_n | output | 1 | Output enable, active low |
| ext_we_n | output | 1 | Write enable, active low |
| ext_dout | output | 32 | Write data toward the device |
| ext_dout_en | output | 1 | Drive enable for write data |
| ext_din | input | 32 | Read data from the device |
| ext_ready | input | 1 | Device Ready |

## Verification
The bench randomizes the strobe offsets and wait counts, including zero CS-on and CS-off. A design that drops an off-by-one in the phase counters would show a latency or chip-select length one cycle off. Narrow banks under word requests catch beat addresses that fail to advance or beats assembled in the wrong byte order, and byte reads on wide banks catch upper lanes that are not cleared. Burst cases check that chip select falls only once and that later beats use the subsequent wait count. Ready cases check three things. A beat that ends on the wait count instead of on Ready is too short. A timeout that fires one cycle off shows up as a wrong chip-select length. A timeout that still fires when disabled cuts the 3001-cycle wait short.

// File: rtl/ebc_pkg.sv
// Shared types for the external bus controller.
// Assumes 32-bit configuration words and a 32-bit data path.
package ebc_pkg;

    localparam int DATA_W = 32;
    localparam int WIN_W  = 12;

    // Timing profile; the packed layout is the low 29 bits of the timing word.
    typedef struct packed {
        logic       to_dis;
        logic       rdy_en;
        logic       burst;
        logic [1:0] we_off;
        logic [1:0] we_on;
        logic [1:0] oe_on;
        logic [1:0] cs_off;
        logic [1:0] cs_on;
        logic [2:0] wait_next;
        logic [4:0] wait_first;
        logic [7:0] wait_nb;
    } tim_t;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_ACT, S_HOLD, S_RESP
    } seq_st_t;

endpackage

// File: rtl/ebc_cfg_regs.sv
// Per-bank configuration store: one map word and one timing word per bank.
// Assumes writes are single-cycle strobes; all words clear on reset.
module ebc_cfg_regs #(
    parameter int NBANK = 8,
    localparam int BW = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [BW-1:0]          cfg_bank,
    input  logic                   cfg_sel,
    input  logic [31:0]            cfg_wdata,
    output logic [NBANK-1:0][31:0] map_o,
    output logic [NBANK-1:0][31:0] tim_o
);

    // Store the addressed word of the addressed bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_o <= '0;
            tim_o <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) tim_o[cfg_bank] <= cfg_wdata;
            else         map_o[cfg_bank] <= cfg_wdata;
        end
    end

endmodule

// File: rtl/ebc_decode.sv
// Address window decoder: masked compare of the top address bits per bank,
// lowest-numbered matching bank wins. Purely combinational.
module ebc_decode #(
    parameter int NBANK = 8,
    parameter int AW    = 32,
    localparam int BW = $clog2(NBANK)
) (
    input  logic [NBANK-1:0][31:0] map_i,
    input  logic [AW-1:0]          addr_i,
    output logic                   hit_o,
    output logic [BW-1:0]          bank_o
);
    import ebc_pkg::*;

    logic [NBANK-1:0] match;

    for (genvar g = 0; g < NBANK; g++) begin : g_win
        // Masked window compare for one bank.
        assign match[g] = map_i[g][7] &&
            (((addr_i[AW-1 -: WIN_W] ^ map_i[g][31:20]) & map_i[g][19:8]) == '0);
    end

    // Priority pick: scanning downward leaves the lowest match.
    always_comb begin
        bank_o = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (match[i]) bank_o = BW'(i);
        end
    end

    assign hit_o = |match;

endmodule

// File: rtl/ebc_seq.sv
// Device-cycle sequencer: runs setup / active / hold phases per beat,
// splits wide requests into beats, handles burst, Ready and timeout, and
// drives the external strobes. Assumes req_addr is aligned to req_size.
module ebc_seq #(
    parameter int NBANK   = 8,
    parameter int AW      = 32,
    parameter int TIMEOUT = 2048,
    localparam int BW   = $clog2(NBANK),
    localparam int TO_W = $clog2(TIMEOUT) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [AW-1:0]     req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              hit,
    input  logic [BW-1:0]     hit_bank,
    input  logic [31:0]       hit_tim,
    input  logic [1:0]        hit_width,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [31:0]       resp_rdata,
    output logic [AW-1:0]     ext_addr,
    output logic [NBANK-1:0]  ext_cs_n,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic [31:0]       ext_dout,
    output logic              ext_dout_en,
    input  logic [31:0]       ext_din,
    input  logic              ext_ready
);
    import ebc_pkg::*;

    seq_st_t         st_q;
    tim_t            tim_q;
    logic [1:0]      dlog_q, size_q, beat_q, last_q;
    logic            wr_q, err_q, fin_q;
    logic [AW-1:0]   addr_q;
    logic [31:0]     wdata_q, acc_q;
    logic [BW-1:0]   bank_q;
    logic [7:0]      cnt_q;
    logic [TO_W-1:0] to_q;

    tim_t       tim_in;
    logic [1:0] dlog_in, slog_in, last_in;
    logic [7:0] wlen;
    logic [1:0] boff;
    logic       busy, more, act_done, tmo, accept;
    logic [31:0] smask;

    // Decode the incoming request's beat count from size and bank width.
    always_comb begin
        tim_in  = tim_t'(hit_tim[28:0]);
        dlog_in = (hit_width == 2'd3) ? 2'd2 : hit_width;
        slog_in = (req_size == 2'd3) ? 2'd2 : req_size;
        last_in = (slog_in > dlog_in) ? 2'((3'd1 << (slog_in - dlog_in)) - 3'd1) : 2'd0;
    end

    // Per-beat quantities: wait count, byte offset, completion conditions.
    always_comb begin
        if (tim_q.burst) wlen = (beat_q == 2'd0) ? 8'(tim_q.wait_first) : 8'(tim_q.wait_next);
        else             wlen = tim_q.wait_nb;
        boff     = 2'(beat_q << dlog_q);
        busy     = (st_q == S_SETUP) || (st_q == S_ACT) || (st_q == S_HOLD);
        more     = (beat_q != last_q);
        act_done = (st_q == S_ACT) && (cnt_q >= wlen) && (!tim_q.rdy_en || ext_ready);
        tmo      = (st_q == S_ACT) && !act_done && tim_q.rdy_en && !tim_q.to_dis &&
                   (to_q == TO_W'(TIMEOUT - 1));
        accept   = req_valid && req_ready;
    end

    assign req_ready = (st_q == S_IDLE);

    // Phase sequencer and per-request state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE; tim_q <= '0; dlog_q <= '0; size_q <= '0;
            beat_q <= '0; last_q <= '0; wr_q <= 1'b0; err_q <= 1'b0;
            fin_q <= 1'b0; addr_q <= '0; wdata_q <= '0; acc_q <= '0;
            bank_q <= '0; cnt_q <= '0; to_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (accept) begin
                    tim_q <= tim_in; dlog_q <= dlog_in; size_q <= req_size;
                    last_q <= last_in; wr_q <= req_write; addr_q <= req_addr;
                    wdata_q <= req_wdata; bank_q <= hit_bank; acc_q <= '0;
                    beat_q <= '0; cnt_q <= '0; to_q <= '0; fin_q <= 1'b0;
                    err_q <= !hit;
                    if (!hit)                    st_q <= S_RESP;
                    else if (tim_in.cs_on == '0) st_q <= S_ACT;
                    else                         st_q <= S_SETUP;
                end
                S_SETUP: begin
                    if (8'(tim_q.cs_on) == cnt_q + 8'd1) begin
                        st_q <= S_ACT; cnt_q <= '0;
                    end else cnt_q <= cnt_q + 8'd1;
                end
                S_ACT: begin
                    to_q <= to_q + 1'b1;
                    if (act_done) begin
                        if (!wr_q) begin
                            case (dlog_q)
                                2'd0:    acc_q[{boff, 3'b000} +: 8]  <= ext_din[7:0];
                                2'd1:    acc_q[{boff, 3'b000} +: 16] <= ext_din[15:0];
                                default: acc_q <= ext_din;
                            endcase
                        end
                        cnt_q <= '0;
                        if (more && tim_q.burst) begin
                            beat_q <= beat_q + 2'd1; to_q <= '0;
                        end else if (more && tim_q.cs_off == '0) begin
                            beat_q <= beat_q + 2'd1; to_q <= '0;
                            st_q <= (tim_q.cs_on == '0) ? S_ACT : S_SETUP;
                        end else if (more) begin
                            st_q <= S_HOLD;
                        end else begin
                            fin_q <= 1'b1;
                            st_q <= (tim_q.cs_off == '0) ? S_RESP : S_HOLD;
                        end
                    end else if (tmo) begin
                        err_q <= 1'b1; fin_q <= 1'b1; acc_q <= '0; cnt_q <= '0;
                        st_q <= (tim_q.cs_off == '0) ? S_RESP : S_HOLD;
                    end else if (cnt_q < wlen) begin
                        cnt_q <= cnt_q + 8'd1;
                    end
                end
                S_HOLD: begin
                    if (8'(tim_q.cs_off) == cnt_q + 8'd1) begin
                        cnt_q <= '0;
                        if (fin_q) st_q <= S_RESP;
                        else begin
                            beat_q <= beat_q + 2'd1; to_q <= '0;
                            st_q <= (tim_q.cs_on == '0) ? S_ACT : S_SETUP;
                        end
                    end else cnt_q <= cnt_q + 8'd1;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Size mask for the returned data.
    always_comb begin
        case (size_q)
            2'd0:    smask = 32'h0000_00FF;
            2'd1:    smask = 32'h0000_FFFF;
            default: smask = 32'hFFFF_FFFF;
        endcase
    end

    // External strobes and data, decoded from phase and counters.
    always_comb begin
        ext_addr    = busy ? addr_q + AW'(boff) : '0;
        ext_cs_n    = '1;
        if (st_q == S_ACT) ext_cs_n[bank_q] = 1'b0;
        ext_oe_n    = !((st_q == S_ACT) && !wr_q &&
                        ((tim_q.burst && beat_q != 2'd0) || cnt_q >= 8'(tim_q.oe_on)));
        ext_we_n    = !((st_q == S_ACT) && wr_q && cnt_q >= 8'(tim_q.we_on) &&
                        (9'(cnt_q) + 9'(tim_q.we_off) <= 9'(wlen)));
        ext_dout_en = busy && wr_q;
        ext_dout    = ext_dout_en ? (wdata_q >> {boff, 3'b000}) : '0;
        resp_valid  = (st_q == S_RESP);
        resp_err    = resp_valid && err_q;
        resp_rdata  = (resp_valid && !wr_q && !err_q) ? (acc_q & smask) : '0;
    end

    // R9: never more than one chip select low.
    a_r9_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));
    // R9: output enable and write enable never low together.
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_oe_n && !ext_we_n));
    // R4: a strobe is only low inside a chip-select window.
    a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_oe_n || !ext_we_n) |-> (ext_cs_n != '1));
    // R2: an unmatched request answers next cycle with an error.
    a_r2_miss_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> (resp_valid && resp_err && ext_cs_n == '1));
    // R2: the response is a single-cycle pulse, after which the block is idle.
    a_r2_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));
    // R3: the address holds still while chip select is low within a beat.
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ACT && !act_done) |=> $stable(ext_addr));

endmodule

// File: rtl/ext_bus_ctrl.sv
// External peripheral bus controller top: configuration store, window
// decoder and device-cycle sequencer. Assumes one outstanding request.
module ext_bus_ctrl #(
    parameter int NBANK   = 8,
    parameter int AW      = 32,
    parameter int TIMEOUT = 2048,
    localparam int BW = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [BW-1:0]    cfg_bank,
    input  logic             cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [AW-1:0]    req_addr,
    input  logic [31:0]      req_wdata,
    output logic             resp_valid,
    output logic             resp_err,
    output logic [31:0]      resp_rdata,
    output logic [AW-1:0]    ext_addr,
    output logic [NBANK-1:0] ext_cs_n,
    output logic             ext_oe_n,
    output logic             ext_we_n,
    output logic [31:0]      ext_dout,
    output logic             ext_dout_en,
    input  logic [31:0]      ext_din,
    input  logic             ext_ready
);

    logic [NBANK-1:0][31:0] map_w, tim_w;
    logic                   hit;
    logic [BW-1:0]          hit_bank;

    ebc_cfg_regs #(.NBANK(NBANK)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .map_o(map_w), .tim_o(tim_w)
    );

    ebc_decode #(.NBANK(NBANK), .AW(AW)) u_dec (
        .map_i(map_w), .addr_i(req_addr), .hit_o(hit), .bank_o(hit_bank)
    );

    ebc_seq #(.NBANK(NBANK), .AW(AW), .TIMEOUT(TIMEOUT)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .hit(hit), .hit_bank(hit_bank), .hit_tim(tim_w[hit_bank]),
        .hit_width(map_w[hit_bank][1:0]),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n),
        .ext_we_n(ext_we_n), .ext_dout(ext_dout), .ext_dout_en(ext_dout_en),
        .ext_din(ext_din), .ext_ready(ext_ready)
    );

endmodule

// File: tb/ext_bus_ctrl_tb.sv
module ext_bus_ctrl_tb;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [2:0]  cfg_bank = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, resp_valid, resp_err;
    logic [31:0] resp_rdata, ext_addr, ext_dout, ext_din;
    logic [7:0]  ext_cs_n;
    logic        ext_oe_n, ext_we_n, ext_dout_en, ext_ready;

    int checks = 0, errors = 0;
    int rdy_delay = 0, lowcnt = 0;
    int n_cs = 0, n_oe = 0, n_we = 0, n_fall = 0;
    logic [7:0] cs_seen = '0;
    logic prev_low = 1'b0;
    int cur_db = 4;
    logic [7:0] wmem [0:255];

    always #4 clk = ~clk;

    ext_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
        .resp_err(resp_err), .resp_rdata(resp_rdata), .ext_addr(ext_addr),
        .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n),
        .ext_dout(ext_dout), .ext_dout_en(ext_dout_en), .ext_din(ext_din),
        .ext_ready(ext_ready)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return (a[7:0] * 8'd7 + 8'd3) ^ {a[11:8], a[11:8]};
    endfunction

    // Device model: byte pattern keyed by address, Ready after a delay.
    always_comb begin
        ext_din   = {pat(ext_addr + 3), pat(ext_addr + 2), pat(ext_addr + 1), pat(ext_addr)};
        ext_ready = (lowcnt >= rdy_delay);
    end

    always @(posedge clk) lowcnt <= (ext_cs_n != 8'hFF) ? lowcnt + 1 : 0;

    // Strobe monitor and write-capture memory.
    always @(negedge clk) begin
        if (ext_cs_n != 8'hFF) begin
            n_cs++;
            cs_seen = cs_seen | ~ext_cs_n;
            if (!prev_low) n_fall++;
        end
        prev_low = (ext_cs_n != 8'hFF);
        if (!ext_oe_n) n_oe++;
        if (!ext_we_n) begin
            n_we++;
            for (int i = 0; i < cur_db; i++) wmem[8'(ext_addr + i)] = ext_dout[i*8 +: 8];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int bank, input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 3'(bank); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] mapw(input logic [11:0] base, input logic [11:0] mask, input logic [1:0] w);
        return {base, mask, 1'b1, 5'b0, w};
    endfunction

    function automatic logic [31:0] timw(input logic tdis, rdy, bst, input int weoff, weon, oeon,
                                         csoff, cson, nxt, fst, nb);
        return {3'b0, tdis, rdy, bst, 2'(weoff), 2'(weon), 2'(oeon), 2'(csoff), 2'(cson),
                3'(nxt), 5'(fst), 8'(nb)};
    endfunction

    function automatic int pos(input int v);
        return (v > 0) ? v : 0;
    endfunction

    // Issue one request; returns busy cycles, error and read data.
    task automatic run(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, output int lat, output logic err,
                       output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(posedge clk);
        n_cs = 0; n_oe = 0; n_we = 0; n_fall = 0; cs_seen = '0;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!resp_valid && lat < 6000) begin
            lat++;
            @(negedge clk);
        end
        if (!resp_valid) check("watchdog", 32'(lat), 32'hFFFF);
        err = resp_err; rd = resp_rdata;
    endtask

    int lat, nbt, db, sb, wl0, wl1, exp_we, exp_oe;
    logic err;
    logic [31:0] rd, ex, wd, a;

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // Reset state
        check("R1 reset cs", 32'(ext_cs_n), 32'hFF);
        check("R4 reset strobes", {30'b0, ext_oe_n, ext_we_n}, 32'h3);
        check("R2 reset ready/resp", {30'b0, req_ready, resp_valid}, 32'h2);
        rst_n = 1'b1;
        // R2: nothing mapped after reset
        run(1'b0, 2'd2, 32'h1000_0000, 0, lat, err, rd);
        check("R2 miss latency", 32'(lat), 0);
        check("R2 miss err", 32'(err), 1);
        check("R2 miss no cs", 32'(cs_seen), 0);
        for (int b = 0; b < 7; b++) cfg(b, 1'b0, mapw(12'(12'h100 + b), 12'hFFF, 2'(b % 3)));

        // Random accesses with random timing profiles
        for (int it = 0; it < 70; it++) begin
            automatic int bank = $urandom % 6;
            automatic int w = $urandom % 3;
            automatic int cson = $urandom % 4, csoff = $urandom % 4, oeon = $urandom % 4;
            automatic int weon = $urandom % 4, weoff = $urandom % 4;
            automatic int nb = (it == 5) ? 255 : $urandom % 6;
            automatic int fst = $urandom % 6, nxt = $urandom % 4;
            automatic logic bst = 1'($urandom % 2), wr = 1'($urandom % 2);
            automatic logic [1:0] sz = 2'($urandom % 3);
            automatic int ccs, cbusy;
            db = 1 << w; sb = 1 << sz;
            nbt = (sb > db) ? sb / db : 1;
            wl0 = bst ? fst : nb; wl1 = bst ? nxt : nb;
            if (weon + weoff > wl0 || weon + weoff > wl1) begin weon = 0; weoff = 0; end
            cfg(bank, 1'b0, mapw(12'(12'h100 + bank), 12'hFFF, 2'(w)));
            cfg(bank, 1'b1, timw(1'b0, 1'b0, bst, weoff, weon, oeon, csoff, cson, nxt, fst, nb));
            cur_db = db;
            rdy_delay = 100000;  // Ready held low: must be ignored (R7)
            a = {12'(12'h100 + bank), 12'h0, 8'(($urandom % 64) * 4)};
            wd = $urandom;
            run(wr, sz, a, wd, lat, err, rd);
            if (bst) begin
                ccs = wl0 + 1 + (nbt - 1) * (wl1 + 1);
                cbusy = cson + ccs + csoff;
                exp_oe = pos(wl0 + 1 - oeon) + (nbt - 1) * (wl1 + 1);
                exp_we = pos(wl0 - weoff - weon + 1) + (nbt - 1) * pos(wl1 - weoff - weon + 1);
                check("R6 burst single cs", 32'(n_fall), 1);
                check("R6 burst latency", 32'(lat), 32'(cbusy));
            end else begin
                ccs = nbt * (nb + 1);
                cbusy = nbt * (cson + nb + 1 + csoff);
                exp_oe = nbt * pos(nb + 1 - oeon);
                exp_we = nbt * pos(nb - weoff - weon + 1);
                check("R3 cs per beat", 32'(n_fall), 32'(nbt));
                check("R3 latency", 32'(lat), 32'(cbusy));
            end
            check("R3 cs low cycles", 32'(n_cs), 32'(ccs));
            check("R1 bank select", 32'(cs_seen), 32'(1 << bank));
            check("R7 ready ignored no err", 32'(err), 0);
            if (wr) begin
                check("R4 we cycles", 32'(n_we), 32'(exp_we));
                check("R4 no oe on write", 32'(n_oe), 0);
                for (int i = 0; i < sb; i++)
                    check("R5 write bytes", 32'(wmem[8'(a + i)]), 32'(wd[i*8 +: 8]));
            end else begin
                ex = '0;
                for (int i = 0; i < sb; i++) ex[i*8 +: 8] = pat(a + i);
                check("R4 oe cycles", 32'(n_oe), 32'(exp_oe));
                check("R5 R10 read data", rd, ex);
            end
        end

        // R7: Ready mode stretches past the wait count
        cur_db = 4;
        cfg(0, 1'b0, mapw(12'h100, 12'hFFF, 2'd2));
        cfg(0, 1'b1, timw(1'b0, 1'b1, 1'b0, 0, 0, 0, 1, 1, 0, 0, 2));
        rdy_delay = 9;
        run(1'b0, 2'd2, 32'h1000_0010, 0, lat, err, rd);
        check("R7 ready latency", 32'(lat), 1 + 10 + 1);
        check("R7 ready data", rd, {pat(32'h1000_0013), pat(32'h1000_0012), pat(32'h1000_0011), pat(32'h1000_0010)});
        rdy_delay = 0;
        run(1'b0, 2'd2, 32'h1000_0010, 0, lat, err, rd);
        check("R7 ready early waits count", 32'(lat), 1 + 3 + 1);
        // R8: timeout
        rdy_delay = 100000;
        run(1'b0, 2'd2, 32'h1000_0020, 0, lat, err, rd);
        check("R8 timeout cs cycles", 32'(n_cs), 2048);
        check("R8 timeout err", 32'(err), 1);
        check("R8 timeout data", rd, 0);
        cfg(0, 1'b1, timw(1'b1, 1'b1, 1'b0, 0, 0, 0, 1, 1, 0, 0, 2));
        rdy_delay = 3000;
        run(1'b0, 2'd2, 32'h1000_0020, 0, lat, err, rd);
        check("R8 disabled cs cycles", 32'(n_cs), 3001);
        check("R8 disabled no err", 32'(err), 0);
        rdy_delay = 0;

        // R1: overlapping windows, lowest bank wins; catch-all bank 6
        cfg(6, 1'b0, mapw(12'h000, 12'h000, 2'd2));
        run(1'b0, 2'd0, 32'h1020_0004, 0, lat, err, rd);
        check("R1 priority low bank", 32'(cs_seen), 32'h04);
        run(1'b0, 2'd0, 32'h3000_0004, 0, lat, err, rd);
        check("R1 catch-all bank", 32'(cs_seen), 32'h40);
        check("R10 byte read masked", rd, {24'h0, pat(32'h3000_0004)});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule